// File: doc/BRIEF.md
# DMA Requester with Adaptive NACK Backoff

The block accepts DMA request beats (read or write, address, transfer tag and beat size) into an eight-entry transmit queue and presents them, oldest first, on a valid/ready request channel. A target may reject a request it has already accepted by returning it on the response channel marked as a negative acknowledge. The rejected beat goes back to the front of the queue, and the block then stays off the channel for a backoff delay counted in clock cycles.

The backoff value adapts to how busy the target is. The first rejection sets it to a programmable floor. Each later rejection doubles it until it has reached a programmable ceiling. Each good response divides it by four. While the value is non-zero, consecutive beats are spaced by the backoff delay and do not go out back to back. A request refused at the handshake (valid high with ready low) is held until the target signals a retry. Good responses add their byte counts to a per-tag running total. When that total reaches the size declared for the transfer, the block pulses a completion output carrying the tag.

Top module: `dma_nack_requester`

## Requirements
- R1: When a NACK response arrives and the backoff value is below `min_backoff`, the backoff becomes `min_backoff`.
- R2: When a NACK response arrives and the backoff is at or above `min_backoff` but below `max_backoff`, the backoff doubles, even if the result exceeds `max_backoff`. When it is already at or above both limits, it is left unchanged.
- R3: A NACK sampled on a clock edge restarts the backoff timer with the new backoff value B, replacing any delay still running. The requeued beat is presented again B+1 cycles after the cycle in which the NACK was presented.
- R4: A NACKed beat is reinserted at the head of the transmit queue, so it is issued before beats that were queued after it.
- R5: Every non-NACK response shifts the backoff value right by two bits.
- R6: While the backoff is zero, queued beats are issued on consecutive cycles.
- R7: When a beat is accepted with a non-zero backoff B and more beats remain queued, the next beat is presented B+1 cycles after the accepting cycle.
- R8: A beat refused at the handshake sets a retry-pending state. While that state is set, `req_valid` is high only in cycles where `retry_in` is high. An accepted handshake clears the state, and normal issue then resumes without any retry.
- R9: A command with `cmd_first` set loads the tag's transfer size and clears its byte total. Good responses add `rsp_bytes` to that total. In the cycle after the response that makes the total equal to the size, `done_valid` pulses with `done_tag`; it stays low after earlier responses.
- R10: `cmd_ready` is high exactly when queued beats plus beats in flight (accepted but not yet answered) number fewer than eight, so a head reinsertion always has room.
- R11: Reset clears the queue, the in-flight count, the backoff value, the timer and the retry-pending state. After reset `cmd_ready` is 1 and `req_valid` is 0, and a newly pushed beat is presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| min_backoff | input | 16 | Backoff floor in cycles |
| max_backoff | input | 16 | Backoff ceiling for doubling, in cycles |
| cmd_valid | input | 1 | Command beat offered |
| cmd_ready | output | 1 | Command beat can be taken |
| cmd_write | input | 1 | 1 = write beat, 0 = read beat |
| cmd_addr | input | 32 | Beat address |
| cmd_tag | input | 2 | Transfer tag |
| cmd_bytes | input | 8 | Beat size in bytes |
| cmd_first | input | 1 | First beat: load transfer size for the tag |
| cmd_total | input | 16 | Transfer size in bytes, used with cmd_first |
| req_valid | output | 1 | Request beat presented |
| req_ready | input | 1 | Target takes the request beat |
| req_write | output | 1 | Write flag of the presented beat |
| req_addr | output | 32 | Address of the presented beat |
| req_tag | output | 2 | Tag of the presented beat |
| req_bytes | output | 8 | Size of the presented beat |
| retry_in | input | 1 | Target allows a refused beat to be resent |
| rsp_valid | input | 1 | Response present |
| rsp_nack | input | 1 | Response is a negative acknowledge |
| rsp_write | input | 1 | Write flag of the answered beat |
| rsp_addr | input | 32 | Address of the answered beat |
| rsp_tag | input | 2 | Tag of the answered beat |
| rsp_bytes | input | 8 | Byte count of the answered beat |
| done_valid | output | 1 | Transfer complete pulse |
| done_tag | output | 2 | Tag of the completed transfer |

## Verification
A pushed beat appears on `req_valid` one cycle after the edge that captures it. A completion pulse appears one cycle after the edge that samples the final response. After a NACK, the requeued beat returns B+1 cycles after the NACK cycle. The bench drives inputs just after the rising edge, samples at the falling edge and logs every accepted handshake with its cycle index. Backoff values that are not visible at the ports are then checked through those gaps: a table of NACK and good-response steps predicts each gap from R1, R2 and R5. Gaps between beats after an accept with non-zero backoff, and the retry windows, are checked by the same cycle arithmetic.

// File: rtl/dnb_pkg.sv
package dnb_pkg;
    localparam int ADDR_W = 32;
    localparam int TAG_W  = 2;
    localparam int BEAT_W = 8;
    localparam int LEN_W  = 16;
    localparam int DLY_W  = 16;
    localparam int BO_W   = 20;
    localparam int QDEPTH = 8;
    localparam int NTAG   = 1 << TAG_W;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  tag;
        logic [BEAT_W-1:0] bytes;
    } dnb_req_t;

    function automatic logic [BO_W-1:0] bo_on_nack(input logic [BO_W-1:0] cur,
                                                  input logic [DLY_W-1:0] lo,
                                                  input logic [DLY_W-1:0] hi);
        logic [BO_W-1:0] lo_w;
        logic [BO_W-1:0] hi_w;
        lo_w = BO_W'(lo);
        hi_w = BO_W'(hi);
        if (cur < lo_w)
            return lo_w;
        else if (cur < hi_w)
            return cur << 1;
        return cur;
    endfunction

    function automatic logic [BO_W-1:0] bo_on_ok(input logic [BO_W-1:0] cur);
        return cur >> 2;
    endfunction
endpackage

// File: rtl/dnb_txq.sv
module dnb_txq
    import dnb_pkg::*;
#(
    parameter int DEPTH = QDEPTH,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_tail,
    input  dnb_req_t      tail_d,
    input  logic          push_head,
    input  dnb_req_t      head_d,
    input  logic          pop,
    output dnb_req_t      front,
    output logic [CW-1:0] count
);
    dnb_req_t      slot [DEPTH];
    logic [PW-1:0] hd;
    logic [PW-1:0] tl;
    logic [PW-1:0] hd_nx;

    // a pop and a head reinsertion in one cycle land in the same slot
    assign hd_nx = hd + PW'(pop) - PW'(push_head);
    assign front = slot[hd];

    always_ff @(posedge clk) begin
        if (rst) begin
            hd    <= '0;
            tl    <= '0;
            count <= '0;
        end else begin
            if (push_tail) begin
                slot[tl] <= tail_d;
                tl       <= tl + PW'(1);
            end
            if (push_head)
                slot[hd_nx] <= head_d;
            hd    <= hd_nx;
            count <= count + CW'(push_tail) + CW'(push_head) - CW'(pop);
        end
    end
endmodule

// File: rtl/dnb_backoff.sv
module dnb_backoff
    import dnb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             nack,
    input  logic             ok,
    input  logic             arm,
    input  logic [DLY_W-1:0] lo,
    input  logic [DLY_W-1:0] hi,
    output logic [BO_W-1:0]  bo,
    output logic             busy
);
    logic [BO_W-1:0] tmr;
    logic [BO_W-1:0] bo_nack;

    assign bo_nack = bo_on_nack(bo, lo, hi);
    assign busy    = (tmr != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            bo  <= '0;
            tmr <= '0;
        end else begin
            if (nack)
                bo <= bo_nack;
            else if (ok)
                bo <= bo_on_ok(bo);

            if (nack)
                tmr <= bo_nack;
            else if (arm)
                tmr <= bo;
            else if (busy)
                tmr <= tmr - BO_W'(1);
        end
    end
endmodule

// File: rtl/dnb_tracker.sv
module dnb_tracker
    import dnb_pkg::*;
#(
    parameter int TAGS = NTAG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [TAG_W-1:0]  load_tag,
    input  logic [LEN_W-1:0]  load_total,
    input  logic              add,
    input  logic [TAG_W-1:0]  add_tag,
    input  logic [BEAT_W-1:0] add_bytes,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag
);
    logic [LEN_W-1:0] total [TAGS];
    logic [LEN_W-1:0] sum   [TAGS];
    logic [TAGS-1:0]  live;
    logic [LEN_W-1:0] sum_nx;

    assign sum_nx = sum[add_tag] + LEN_W'(add_bytes);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAGS; i++) begin
                total[i] <= '0;
                sum[i]   <= '0;
            end
            live       <= '0;
            done_valid <= 1'b0;
            done_tag   <= '0;
        end else begin
            done_valid <= 1'b0;
            if (add && live[add_tag]) begin
                sum[add_tag] <= sum_nx;
                if (sum_nx == total[add_tag]) begin
                    done_valid     <= 1'b1;
                    done_tag       <= add_tag;
                    live[add_tag]  <= 1'b0;
                end
            end
            if (load) begin
                total[load_tag] <= load_total;
                sum[load_tag]   <= '0;
                live[load_tag]  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dma_nack_requester.sv
module dma_nack_requester
    import dnb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DLY_W-1:0]  min_backoff,
    input  logic [DLY_W-1:0]  max_backoff,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic              cmd_write,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [TAG_W-1:0]  cmd_tag,
    input  logic [BEAT_W-1:0] cmd_bytes,
    input  logic              cmd_first,
    input  logic [LEN_W-1:0]  cmd_total,
    output logic              req_valid,
    input  logic              req_ready,
    output logic              req_write,
    output logic [ADDR_W-1:0] req_addr,
    output logic [TAG_W-1:0]  req_tag,
    output logic [BEAT_W-1:0] req_bytes,
    input  logic              retry_in,
    input  logic              rsp_valid,
    input  logic              rsp_nack,
    input  logic              rsp_write,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [BEAT_W-1:0] rsp_bytes,
    output logic              done_valid,
    output logic [TAG_W-1:0]  done_tag
);
    localparam int CW = $clog2(QDEPTH + 1);

    dnb_req_t        cmd_beat;
    dnb_req_t        back_beat;
    dnb_req_t        front;
    logic [CW-1:0]   count;
    logic [CW-1:0]   inflight;
    logic [CW:0]     occupancy;
    logic            push_t;
    logic            push_h;
    logic            accept;
    logic            arm;
    logic            good_rsp;
    logic            retry_pend;
    logic            tmr_busy;
    logic [BO_W-1:0] bo_val;

    assign cmd_beat  = '{wr: cmd_write, addr: cmd_addr, tag: cmd_tag, bytes: cmd_bytes};
    assign back_beat = '{wr: rsp_write, addr: rsp_addr, tag: rsp_tag, bytes: rsp_bytes};

    assign occupancy = {1'b0, count} + {1'b0, inflight};
    assign cmd_ready = occupancy < (CW+1)'(QDEPTH);
    assign push_t    = cmd_valid && cmd_ready;
    assign push_h    = rsp_valid && rsp_nack;
    assign good_rsp  = rsp_valid && !rsp_nack;

    assign req_valid = (count != '0) && !tmr_busy && (!retry_pend || retry_in);
    assign accept    = req_valid && req_ready;
    assign arm       = accept && ((count > CW'(1)) || push_t);

    assign req_write = front.wr;
    assign req_addr  = front.addr;
    assign req_tag   = front.tag;
    assign req_bytes = front.bytes;

    always_ff @(posedge clk) begin
        if (rst) begin
            retry_pend <= 1'b0;
            inflight   <= '0;
        end else begin
            if (accept)
                retry_pend <= 1'b0;
            else if (req_valid && !req_ready)
                retry_pend <= 1'b1;
            inflight <= inflight + CW'(accept) - CW'(rsp_valid);
        end
    end

    dnb_txq #(.DEPTH(QDEPTH)) txq_i (
        .clk       (clk),
        .rst       (rst),
        .push_tail (push_t),
        .tail_d    (cmd_beat),
        .push_head (push_h),
        .head_d    (back_beat),
        .pop       (accept),
        .front     (front),
        .count     (count)
    );

    dnb_backoff backoff_i (
        .clk  (clk),
        .rst  (rst),
        .nack (push_h),
        .ok   (good_rsp),
        .arm  (arm),
        .lo   (min_backoff),
        .hi   (max_backoff),
        .bo   (bo_val),
        .busy (tmr_busy)
    );

    dnb_tracker #(.TAGS(NTAG)) tracker_i (
        .clk        (clk),
        .rst        (rst),
        .load       (push_t && cmd_first),
        .load_tag   (cmd_tag),
        .load_total (cmd_total),
        .add        (good_rsp),
        .add_tag    (rsp_tag),
        .add_bytes  (rsp_bytes),
        .done_valid (done_valid),
        .done_tag   (done_tag)
    );
endmodule

// File: rtl/dma_nack_requester_chk.sv
module dma_nack_requester_chk
    import dnb_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             rsp_valid,
    input logic             rsp_nack,
    input logic             req_valid,
    input logic             req_ready,
    input logic             retry_in,
    input logic             busy,
    input logic             done_valid,
    input logic [BO_W-1:0]  bo,
    input logic [DLY_W-1:0] mn,
    input logic [DLY_W-1:0] mx
);
    // R1
    floor_load_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_nack && bo < BO_W'(mn)) |=> (bo == BO_W'($past(mn))));

    // R2
    double_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_nack && bo >= BO_W'(mn) && bo < BO_W'(mx))
        |=> (bo == ($past(bo) << 1)));

    // R2
    ceiling_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_nack && bo >= BO_W'(mn) && bo >= BO_W'(mx)) |=> $stable(bo));

    // R5
    shrink_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_nack) |=> (bo == ($past(bo) >> 2)));

    // R3
    quiet_while_timing_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !req_valid);

    // R8
    hold_after_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !retry_in) |=> (!req_valid || retry_in));

    // R9
    done_after_good_chk: assert property (@(posedge clk) disable iff (rst)
        done_valid |-> $past(rsp_valid && !rsp_nack));
endmodule

bind dma_nack_requester dma_nack_requester_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .rsp_valid  (rsp_valid),
    .rsp_nack   (rsp_nack),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .retry_in   (retry_in),
    .busy       (tmr_busy),
    .done_valid (done_valid),
    .bo         (bo_val),
    .mn         (min_backoff),
    .mx         (max_backoff)
);

// File: tb/dma_nack_requester_tb_top.sv
`timescale 1ns/1ps
module dma_nack_requester_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] min_backoff = 16'd4;
    logic [15:0] max_backoff = 16'd20;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic        cmd_write = 1'b0;
    logic [31:0] cmd_addr = '0;
    logic [1:0]  cmd_tag = '0;
    logic [7:0]  cmd_bytes = 8'd4;
    logic        cmd_first = 1'b0;
    logic [15:0] cmd_total = '0;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic        req_write;
    logic [31:0] req_addr;
    logic [1:0]  req_tag;
    logic [7:0]  req_bytes;
    logic        retry_in = 1'b0;
    logic        rsp_valid = 1'b0;
    logic        rsp_nack = 1'b0;
    logic        rsp_write = 1'b0;
    logic [31:0] rsp_addr = '0;
    logic [1:0]  rsp_tag = '0;
    logic [7:0]  rsp_bytes = 8'd4;
    logic        done_valid;
    logic [1:0]  done_tag;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int acc_n = 0;
    int acc_cyc [64];
    logic [31:0] acc_addr [64];
    int nack_cyc = 0;
    bit finished = 1'b0;

    // bit 8: 1 = NACK step, 0 = good response; low byte: expected gap
    localparam logic [8:0] VEC [12] = '{
        9'h105, 9'h109, 9'h111, 9'h121, 9'h121, 9'h000,
        9'h111, 9'h000, 9'h000, 9'h105, 9'h000, 9'h000
    };

    always #2.5 clk = ~clk;

    dma_nack_requester dut_i (.*);

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (!rst && req_valid && req_ready && acc_n < 64) begin
            acc_addr[acc_n] = req_addr;
            acc_cyc[acc_n]  = cyc;
            acc_n = acc_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic sample();
        @(negedge clk);
        #0.5;
    endtask

    task automatic push(input logic [31:0] a, input logic [1:0] t,
                        input logic first, input logic [15:0] tot);
        cmd_valid = 1'b1;
        cmd_addr  = a;
        cmd_tag   = t;
        cmd_first = first;
        cmd_total = tot;
        tick();
        cmd_valid = 1'b0;
        cmd_first = 1'b0;
    endtask

    task automatic respond(input logic nk, input logic [31:0] a, input logic [1:0] t);
        rsp_valid = 1'b1;
        rsp_nack  = nk;
        rsp_addr  = a;
        rsp_tag   = t;
        nack_cyc  = cyc + 1;
        tick();
        rsp_valid = 1'b0;
        rsp_nack  = 1'b0;
    endtask

    task automatic wait_acc(input int n);
        while (acc_n < n) tick();
    endtask

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        summary();
    end

    initial begin
        int k;
        int gap;
        tick(); tick(); tick();
        rst = 1'b0;
        sample();
        // R11 reset state
        chk(cmd_ready == 1'b1, "R11 cmd_ready after reset", int'(cmd_ready), 1);
        chk(req_valid == 1'b0, "R11 req_valid after reset", int'(req_valid), 0);
        chk(done_valid == 1'b0, "R11 done_valid after reset", int'(done_valid), 0);

        // R10 capacity with target refusing
        tick();
        req_ready = 1'b0;
        for (int i = 0; i < 8; i++) begin
            push(32'h1000 + 32'(i * 4), 2'd3, 1'b0, 16'd0);
            if (i == 6) begin
                sample();
                chk(cmd_ready == 1'b1, "R10 cmd_ready at seven", int'(cmd_ready), 1);
                tick();
            end
        end
        sample();
        chk(cmd_ready == 1'b0, "R10 cmd_ready at eight", int'(cmd_ready), 0);
        tick();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        req_ready = 1'b1;
        sample();
        chk(cmd_ready == 1'b1 && req_valid == 1'b0, "R11 queue cleared by reset",
            int'({cmd_ready, req_valid}), 2);
        tick();

        // R6 back to back with zero backoff
        k = acc_n;
        push(32'h10, 2'd0, 1'b1, 16'd12);
        push(32'h14, 2'd0, 1'b0, 16'd0);
        push(32'h18, 2'd0, 1'b0, 16'd0);
        wait_acc(k + 3);
        chk(acc_cyc[k+1] - acc_cyc[k] == 1, "R6 gap first pair", acc_cyc[k+1] - acc_cyc[k], 1);
        chk(acc_cyc[k+2] - acc_cyc[k+1] == 1, "R6 gap second pair", acc_cyc[k+2] - acc_cyc[k+1], 1);
        chk(acc_addr[k+2] == 32'h18, "R6 issue order", int'(acc_addr[k+2]), 32'h18);

        // R9 completion after the exact total
        respond(1'b0, 32'h10, 2'd0);
        sample();
        chk(done_valid == 1'b0, "R9 no done after 4 of 12", int'(done_valid), 0);
        tick();
        respond(1'b0, 32'h14, 2'd0);
        sample();
        chk(done_valid == 1'b0, "R9 no done after 8 of 12", int'(done_valid), 0);
        tick();
        respond(1'b0, 32'h18, 2'd0);
        sample();
        chk(done_valid == 1'b1 && done_tag == 2'd0, "R9 done at 12 of 12",
            int'({done_valid, done_tag}), 4);
        tick();

        // R8 refusal and retry
        req_ready = 1'b0;
        push(32'h40, 2'd2, 1'b1, 16'd8);
        sample();
        chk(req_valid == 1'b1, "R8 first presentation", int'(req_valid), 1);
        tick();
        sample();
        chk(req_valid == 1'b0, "R8 held after refusal", int'(req_valid), 0);
        tick();
        retry_in = 1'b1;
        sample();
        chk(req_valid == 1'b1, "R8 presented on retry", int'(req_valid), 1);
        tick();
        retry_in = 1'b0;
        sample();
        chk(req_valid == 1'b0, "R8 still pending after refused retry", int'(req_valid), 0);
        tick();
        retry_in  = 1'b1;
        req_ready = 1'b1;
        k = acc_n;
        tick();
        retry_in = 1'b0;
        chk(acc_n == k + 1 && acc_addr[k] == 32'h40, "R8 accepted on retry",
            int'(acc_addr[k]), 32'h40);
        push(32'h44, 2'd2, 1'b0, 16'd0);
        sample();
        chk(req_valid == 1'b1 && req_addr == 32'h44, "R8 pending cleared",
            int'(req_addr), 32'h44);
        tick();
        respond(1'b0, 32'h40, 2'd2);
        respond(1'b0, 32'h44, 2'd2);
        sample();
        chk(done_valid == 1'b1 && done_tag == 2'd2, "R9 done for tag 2",
            int'({done_valid, done_tag}), 6);
        tick();

        // R1 R2 R3 R5 backoff table
        k = acc_n;
        push(32'h100, 2'd1, 1'b1, 16'hFFFF);
        wait_acc(k + 1);
        for (int i = 0; i < 12; i++) begin
            k = acc_n;
            if (VEC[i][8]) begin
                respond(1'b1, 32'h100, 2'd1);
                wait_acc(k + 1);
                gap = acc_cyc[k] - nack_cyc;
                if (i == 0 || i == 9)
                    chk(gap == int'(VEC[i][7:0]), "R1 floor gap", gap, int'(VEC[i][7:0]));
                else if (i == 3 || i == 4)
                    chk(gap == int'(VEC[i][7:0]), "R2 ceiling gap", gap, int'(VEC[i][7:0]));
                else if (i == 6)
                    chk(gap == int'(VEC[i][7:0]), "R5 gap after shrink", gap, int'(VEC[i][7:0]));
                else
                    chk(gap == int'(VEC[i][7:0]), "R3 restart gap", gap, int'(VEC[i][7:0]));
            end else begin
                respond(1'b0, 32'h100, 2'd1);
                push(32'h100, 2'd1, 1'b0, 16'd0);
                wait_acc(k + 1);
            end
        end
        respond(1'b0, 32'h100, 2'd1);

        // R4 head reinsertion, R7 spacing under backoff
        k = acc_n;
        push(32'h200, 2'd1, 1'b0, 16'd0);
        wait_acc(k + 1);
        req_ready = 1'b0;
        push(32'h204, 2'd1, 1'b0, 16'd0);
        tick();
        k = acc_n;
        respond(1'b1, 32'h200, 2'd1);
        req_ready = 1'b1;
        retry_in  = 1'b1;
        wait_acc(k + 2);
        retry_in  = 1'b0;
        chk(acc_addr[k] == 32'h200, "R4 requeued beat first", int'(acc_addr[k]), 32'h200);
        chk(acc_addr[k+1] == 32'h204, "R4 later beat second", int'(acc_addr[k+1]), 32'h204);
        chk(acc_cyc[k] - nack_cyc == 5, "R3 gap from zero backoff", acc_cyc[k] - nack_cyc, 5);
        chk(acc_cyc[k+1] - acc_cyc[k] == 5, "R7 armed spacing", acc_cyc[k+1] - acc_cyc[k], 5);

        // R11 reset while the timer runs
        respond(1'b1, 32'h204, 2'd1);
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        sample();
        chk(req_valid == 1'b0 && cmd_ready == 1'b1, "R11 mid-run reset",
            int'({cmd_ready, req_valid}), 2);
        tick();
        push(32'h300, 2'd0, 1'b0, 16'd0);
        sample();
        chk(req_valid == 1'b1 && req_addr == 32'h300, "R11 timer cleared",
            int'(req_addr), 32'h300);
        tick();
        summary();
    end
endmodule